// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block keeps the working state of one DMA channel: a source address, a destination address and a remaining-unit count. Software loads and reads the three values through a small register port. A transfer engine tells the block when a unit starts and when it completes, which unit size is in use, and how each side's address should move. On every completed unit the block steps the addresses by the unit size and takes one off the count. Each address output therefore always shows the address that the next unit will use.

The count field is 24 bits wide, and a loaded value of zero stands for the full 2^24 units. A 16-byte block counts as one unit, the same as a byte, word or longword. In single-address mode one side is an external device that the engine acknowledges directly. That side's address is frozen, is not driven onto the bus and is not checked for alignment. A terminal-count flag reports that the count has reached zero. A sticky alignment-error flag reports any unit that began from a misaligned active address.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset both addresses and the count are zero, and the terminal-count and alignment-error flags are low.
- R2: A register write with `reg_sel` 0, 1 or 2 loads the source address, the destination address or the count (bits 23:0) respectively. Reads through the same selects return the current values. Bits 31:24 of a count read are always zero, whatever was written. Select 3 reads as zero.
- R3: Each `xfer_done` pulse lowers the count by exactly one for every unit size, including the 16-byte block size (`xfer_size` = 3).
- R4: A count of 0 steps to 0xFFFFFF, so a loaded zero runs 2^24 units. `term_cnt` rises on the edge where a completion takes the count from 1 to 0. It stays high until the count register is written.
- R5: On `xfer_done` an active side moves by the unit size in bytes (size 0/1/2/3 gives 1/2/4/16). Its 2-bit mode sets the direction: 0 keeps the address fixed, 1 increments, 2 decrements, and 3 keeps it fixed.
- R6: With `single_addr` high, the device side (source when `dev_on_src` is 1, otherwise destination) keeps its address through completions. Its drive output (`src_drive`/`dst_drive`) is low, and it never raises an alignment error. The other side behaves as in R5 and R7.
- R7: An `xfer_start` pulse sets `align_err` when an active address is misaligned. Word units need bit 0 clear and longword units need bits 1:0 clear. Block units need source bits 3:0 clear and destination bits 1:0 clear. Byte units are never misaligned. Writing an address register clears only that side's error.
- R8: When a software write and a completion update the same register in one cycle, the written value is kept. The other registers still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| xfer_start | input | 1 | A unit begins (alignment is sampled) |
| xfer_done | input | 1 | A unit has completed |
| xfer_size | input | 2 | Unit size: 0 byte, 1 word, 2 longword, 3 16-byte block |
| src_mode | input | 2 | Source address mode |
| dst_mode | input | 2 | Destination address mode |
| single_addr | input | 1 | Single-address mode enable |
| dev_on_src | input | 1 | In single-address mode, device sits on the source side |
| src_addr | output | 32 | Next source address |
| dst_addr | output | 32 | Next destination address |
| src_drive | output | 1 | Source address is used on the bus |
| dst_drive | output | 1 | Destination address is used on the bus |
| remain_cnt | output | 24 | Remaining unit count |
| term_cnt | output | 1 | Terminal count reached |
| align_err | output | 1 | Sticky alignment error |

## Verification
Stepping is swept over every pair of unit size and mode on both sides, with three completions each. Expected addresses are computed as base plus or minus a multiple of the step. This separates the four step widths and tells the reserved mode apart from increment and decrement. Alignment is swept over all sixteen low-address offsets for each size on the source, and over four offsets on the destination. This tells the 16-byte source rule from the longword rule used on the destination. The count is driven through the 0-to-maximum wrap and the 1-to-0 edge. Single-address runs and same-cycle write/completion collisions show that the device side stays frozen and that software wins.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_BLK16 = 2'b11
  } unit_size_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_RSVD  = 2'b11
  } addr_mode_e;

  localparam int unsigned STEP_W = 5;

  // Bytes moved by one unit of the given size.
  function automatic logic [STEP_W-1:0] unit_bytes(input unit_size_e sz);
    case (sz)
      SZ_BYTE:  unit_bytes = STEP_W'(1);
      SZ_WORD:  unit_bytes = STEP_W'(2);
      SZ_LONG:  unit_bytes = STEP_W'(4);
      default:  unit_bytes = STEP_W'(16);
    endcase
  endfunction

  // Low address bits that must be clear for a unit of this size.
  function automatic logic is_misaligned(input logic [3:0] low,
                                         input unit_size_e sz,
                                         input logic src_side);
    case (sz)
      SZ_BYTE:  is_misaligned = 1'b0;
      SZ_WORD:  is_misaligned = low[0];
      SZ_LONG:  is_misaligned = |low[1:0];
      default:  is_misaligned = src_side ? (|low) : (|low[1:0]);
    endcase
  endfunction

endpackage

// File: rtl/dma_side_addr.sv
`timescale 1ns/1ps
module dma_side_addr
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter bit          IS_SRC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              active,
  input  logic              start,
  input  logic              done,
  input  unit_size_e        size,
  input  addr_mode_e        mode,
  output logic [ADDR_W-1:0] addr,
  output logic              err
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] step_ext;
  logic              addr_en;
  logic              err_q, err_d, err_en;
  logic              bad_now;

  assign step_ext = ADDR_W'(unit_bytes(size));
  assign bad_now  = active & is_misaligned(addr_q[3:0], size, IS_SRC);

  // Next-state: address
  always_comb begin
    addr_d = addr_q;
    case (mode)
      AM_INC:  addr_d = addr_q + step_ext;
      AM_DEC:  addr_d = addr_q - step_ext;
      default: addr_d = addr_q;
    endcase
    if (wr_en) addr_d = wr_data;
  end

  assign addr_en = wr_en | (done & active);

  // Next-state: sticky alignment error
  always_comb begin
    err_d = err_q;
    if (wr_en)                err_d = 1'b0;
    else if (start && bad_now) err_d = 1'b1;
  end

  assign err_en = wr_en | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (err_en)  err_q  <= err_d;
    end
  end

  assign addr = addr_q;
  assign err  = err_q;

  // R8: software write lands even when a completion arrives together
  p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> addr == $past(wr_data));

  // R6: an inactive side or a quiet cycle leaves the address alone
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && (!active || !done)) |=> $stable(addr));

  // R7: writing this side's address clears its error
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !err);

  // R6: an inactive side never raises an error on its own
  p_no_err_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !err) |=> !err);

endmodule

// File: rtl/dma_xfer_count.sv
`timescale 1ns/1ps
module dma_xfer_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             done,
  output logic [CNT_W-1:0] cnt,
  output logic             tc
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tc_q, tc_d, tc_en;

  // Zero wraps to all-ones: a loaded zero means the full range.
  always_comb begin
    cnt_d = cnt_q - ONE;
    if (wr_en) cnt_d = wr_data;
  end

  assign cnt_en = wr_en | done;

  always_comb begin
    tc_d = tc_q;
    if (wr_en)                      tc_d = 1'b0;
    else if (done && cnt_q == ONE)  tc_d = 1'b1;
  end

  assign tc_en = wr_en | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (tc_en)  tc_q  <= tc_d;
    end
  end

  assign cnt = cnt_q;
  assign tc  = tc_q;

  // R3: one completion, one unit off the count
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en) |=> cnt == $past(cnt) - ONE);

  // R4: the 1-to-0 completion raises terminal count
  p_tc_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_en && cnt == ONE) |=> tc);

  // R4: terminal count is held until software reloads the count
  p_tc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !wr_en) |=> tc);

  // R8: a write beats a same-cycle completion
  p_cnt_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_data) && !tc));

endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_start,
  input  logic              xfer_done,
  input  logic [1:0]        xfer_size,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic              single_addr,
  input  logic              dev_on_src,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              src_drive,
  output logic              dst_drive,
  output logic [CNT_W-1:0]  remain_cnt,
  output logic              term_cnt,
  output logic              align_err
);

  localparam int unsigned NSIDE   = 2;
  localparam logic [1:0]  SEL_SRC = 2'd0;
  localparam logic [1:0]  SEL_DST = 2'd1;
  localparam logic [1:0]  SEL_CNT = 2'd2;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              side_wr   [NSIDE];
  logic              side_act  [NSIDE];
  addr_mode_e        side_mode [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];
  logic              side_err  [NSIDE];
  unit_size_e        size_e;
  logic              cnt_wr;

  assign size_e       = unit_size_e'(xfer_size);
  assign side_act[0]  = ~(single_addr & dev_on_src);
  assign side_act[1]  = ~(single_addr & ~dev_on_src);
  assign side_mode[0] = addr_mode_e'(src_mode);
  assign side_mode[1] = addr_mode_e'(dst_mode);
  assign side_wr[0]   = reg_wr & (reg_sel == SEL_SRC);
  assign side_wr[1]   = reg_wr & (reg_sel == SEL_DST);
  assign cnt_wr       = reg_wr & (reg_sel == SEL_CNT);

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_side_addr #(
      .ADDR_W (ADDR_W),
      .IS_SRC (g == 0)
    ) i_side (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wr_en   (side_wr[g]),
      .wr_data (ADDR_W'(reg_wdata)),
      .active  (side_act[g]),
      .start   (xfer_start),
      .done    (xfer_done),
      .size    (size_e),
      .mode    (side_mode[g]),
      .addr    (side_addr[g]),
      .err     (side_err[g])
    );
  end

  dma_xfer_count #(
    .CNT_W (CNT_W)
  ) i_count (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cnt_wr),
    .wr_data (CNT_W'(reg_wdata)),
    .done    (xfer_done),
    .cnt     (remain_cnt),
    .tc      (term_cnt)
  );

  // Read mux
  always_comb begin
    case (reg_sel)
      SEL_SRC: reg_rdata = DATA_W'(side_addr[0]);
      SEL_DST: reg_rdata = DATA_W'(side_addr[1]);
      SEL_CNT: reg_rdata = DATA_W'(remain_cnt);
      default: reg_rdata = '0;
    endcase
  end

  assign src_addr  = side_addr[0];
  assign dst_addr  = side_addr[1];
  assign src_drive = side_act[0];
  assign dst_drive = side_act[1];
  assign align_err = side_err[0] | side_err[1];

  // R2: the upper count byte never reads back non-zero
  p_cnt_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_sel == SEL_CNT) |-> (reg_rdata >> CNT_W) == '0);

  // R6: the device-side source address stays put in single-address mode
  p_dev_src_frozen_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (single_addr && dev_on_src && !side_wr[0]) |=> $stable(src_addr));

  // R6: exactly one side is driven in single-address mode
  p_one_drive_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    single_addr |-> $countones({src_drive, dst_drive}) == 1);

endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        xfer_start;
  logic        xfer_done;
  logic [1:0]  xfer_size;
  logic [1:0]  src_mode;
  logic [1:0]  dst_mode;
  logic        single_addr;
  logic        dev_on_src;
  logic [31:0] src_addr;
  logic [31:0] dst_addr;
  logic        src_drive;
  logic        dst_drive;
  logic [23:0] remain_cnt;
  logic        term_cnt;
  logic        align_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  dma_chan_regs i_dma_chan_regs (
    .clk (clk), .rst_n (rst_n),
    .reg_wr (reg_wr), .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
    .xfer_start (xfer_start), .xfer_done (xfer_done), .xfer_size (xfer_size),
    .src_mode (src_mode), .dst_mode (dst_mode),
    .single_addr (single_addr), .dev_on_src (dev_on_src),
    .src_addr (src_addr), .dst_addr (dst_addr),
    .src_drive (src_drive), .dst_drive (dst_drive),
    .remain_cnt (remain_cnt), .term_cnt (term_cnt), .align_err (align_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All stimulus tasks start and end at a falling edge.
  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] val);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #0.5;
    val = reg_rdata;
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic pulse_start();
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  function automatic logic [31:0] step_of(input int sz);
    return (sz == 3) ? 32'd16 : (32'd1 << sz);
  endfunction

  function automatic logic [31:0] moved(input logic [31:0] base, input int md,
                                        input int sz, input int k);
    if (md == 1) return base + step_of(sz) * k;
    if (md == 2) return base - step_of(sz) * k;
    return base;
  endfunction

  function automatic logic bad_low(input logic [3:0] low, input int sz, input bit src);
    case (sz)
      0: return 1'b0;
      1: return low[0];
      2: return |low[1:0];
      default: return src ? |low : |low[1:0];
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    xfer_start = 0; xfer_done = 0; xfer_size = 0;
    src_mode = 0; dst_mode = 0; single_addr = 0; dev_on_src = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 src", src_addr, 32'h0);
    chk("R1 dst", dst_addr, 32'h0);
    chk("R1 cnt", {8'h0, remain_cnt}, 32'h0);
    chk("R1 tc", {31'h0, term_cnt}, 32'h0);
    chk("R1 err", {31'h0, align_err}, 32'h0);

    // R5/R3 stepping sweep over size x mode on both sides
    for (int sz = 0; sz < 4; sz++) begin
      for (int md = 0; md < 4; md++) begin
        int dmd;
        dmd = (md + 1) % 4;
        xfer_size = sz[1:0]; src_mode = md[1:0]; dst_mode = dmd[1:0];
        wr_reg(2'd0, 32'h4000_0000);
        wr_reg(2'd1, 32'h8000_0100);
        wr_reg(2'd2, 32'd5);
        for (int k = 0; k < 3; k++) pulse_done();
        chk("R5 src step", src_addr, moved(32'h4000_0000, md, sz, 3));
        chk("R5 dst step", dst_addr, moved(32'h8000_0100, dmd, sz, 3));
        chk("R3 count per unit", {8'h0, remain_cnt}, 32'd2);
        rd_reg(2'd0, rv);
        chk("R2 src read", rv, moved(32'h4000_0000, md, sz, 3));
        rd_reg(2'd1, rv);
        chk("R2 dst read", rv, moved(32'h8000_0100, dmd, sz, 3));
      end
    end

    // R4 count wrap and terminal count
    wr_reg(2'd2, 32'd0);
    pulse_done();
    chk("R4 zero wraps", {8'h0, remain_cnt}, 32'h00FF_FFFF);
    chk("R4 no tc on wrap", {31'h0, term_cnt}, 32'h0);
    wr_reg(2'd2, 32'd2);
    pulse_done();
    chk("R4 cnt 1", {8'h0, remain_cnt}, 32'd1);
    chk("R4 tc low at 1", {31'h0, term_cnt}, 32'h0);
    pulse_done();
    chk("R4 cnt 0", {8'h0, remain_cnt}, 32'd0);
    chk("R4 tc set", {31'h0, term_cnt}, 32'h1);
    pulse_done();
    chk("R4 tc held", {31'h0, term_cnt}, 32'h1);
    chk("R4 cnt after 0", {8'h0, remain_cnt}, 32'h00FF_FFFF);
    wr_reg(2'd2, 32'd7);
    chk("R4 tc cleared by write", {31'h0, term_cnt}, 32'h0);

    // R2 upper byte and unused select
    wr_reg(2'd2, 32'hAB00_0003);
    rd_reg(2'd2, rv);
    chk("R2 count upper zero", rv, 32'h0000_0003);
    rd_reg(2'd3, rv);
    chk("R2 select 3 zero", rv, 32'h0);

    // R7 source alignment sweep
    src_mode = 2'd1; dst_mode = 2'd1;
    for (int sz = 0; sz < 4; sz++) begin
      xfer_size = sz[1:0];
      for (int off = 0; off < 16; off++) begin
        wr_reg(2'd1, 32'h0000_0200);
        wr_reg(2'd0, 32'h0000_0100 + off);
        pulse_start();
        chk("R7 src align", {31'h0, align_err}, {31'h0, bad_low(off[3:0], sz, 1'b1)});
        wr_reg(2'd0, 32'h0000_0100);
        chk("R7 src clear", {31'h0, align_err}, 32'h0);
      end
      for (int off = 0; off < 4; off++) begin
        wr_reg(2'd1, 32'h0000_0200 + off);
        pulse_start();
        chk("R7 dst align", {31'h0, align_err}, {31'h0, bad_low(off[3:0], sz, 1'b0)});
        wr_reg(2'd1, 32'h0000_0200);
        chk("R7 dst clear", {31'h0, align_err}, 32'h0);
      end
    end

    // R7 clearing is per side
    xfer_size = 2'd1;
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd1, 32'h1);
    pulse_start();
    wr_reg(2'd0, 32'h10);
    chk("R7 dst error survives src write", {31'h0, align_err}, 32'h1);
    wr_reg(2'd1, 32'h20);
    chk("R7 cleared both", {31'h0, align_err}, 32'h0);

    // R6 single-address, device on source
    single_addr = 1; dev_on_src = 1; xfer_size = 2'd2;
    wr_reg(2'd0, 32'h0000_0003);
    wr_reg(2'd1, 32'h0000_1000);
    pulse_start();
    chk("R6 no err on device side", {31'h0, align_err}, 32'h0);
    pulse_done(); pulse_done();
    chk("R6 src frozen", src_addr, 32'h0000_0003);
    chk("R6 dst steps", dst_addr, 32'h0000_1008);
    chk("R6 src not driven", {31'h0, src_drive}, 32'h0);
    chk("R6 dst driven", {31'h0, dst_drive}, 32'h1);

    // R6 single-address, device on destination
    dev_on_src = 0;
    wr_reg(2'd0, 32'h0000_2000);
    wr_reg(2'd1, 32'h0000_0001);
    pulse_start();
    chk("R6 no err dst device", {31'h0, align_err}, 32'h0);
    pulse_done();
    chk("R6 dst frozen", dst_addr, 32'h0000_0001);
    chk("R6 src steps", src_addr, 32'h0000_2004);
    chk("R6 dst not driven", {31'h0, dst_drive}, 32'h0);
    single_addr = 0;

    // R8 write beats a same-cycle completion
    xfer_size = 2'd0; src_mode = 2'd1; dst_mode = 2'd1;
    wr_reg(2'd0, 32'h100);
    wr_reg(2'd1, 32'h200);
    wr_reg(2'd2, 32'd20);
    reg_wr = 1; reg_sel = 2'd0; reg_wdata = 32'h5000; xfer_done = 1;
    @(negedge clk);
    reg_wr = 0; xfer_done = 0;
    chk("R8 src write wins", src_addr, 32'h5000);
    chk("R8 dst still steps", dst_addr, 32'h201);
    chk("R8 count still steps", {8'h0, remain_cnt}, 32'd19);
    reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'd9; xfer_done = 1;
    @(negedge clk);
    reg_wr = 0; xfer_done = 0;
    chk("R8 count write wins", {8'h0, remain_cnt}, 32'd9);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule